// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the register side of a small accumulator machine. A single 16-bit bus carries one word per cycle from one of seven sources: the address register, the program counter, the data register, the accumulator value (supplied from outside), the instruction register, the temporary register and the memory read word. A one-hot set of source requests is encoded into a 3-bit select code. That code picks the bus driver, and each destination register samples the bus under its own strobes.

The 12-bit address register and program counter put zeros in the four upper bus bits when they drive the bus. When they load, they keep only the low 12 bits. The 8-bit output register keeps only the low byte. The address, program counter, data and temporary registers each have synchronous clear, load and increment strobes. When strobes coincide, clear wins over load, and load wins over increment. The instruction and output registers load only. The memory address always comes from the address register, and the memory write word is the bus. The sequencer that drives the strobes, the accumulator arithmetic and the memory array all sit outside this block.

Top module: `busreg_datapath`

## Requirements
- R1: Select code 1 drives the address register onto the bus, 2 the program counter, 3 the data register, 4 the accumulator input, 5 the instruction register, 6 the temporary register and 7 the memory read word.
- R2: Select code 0 (no request) puts all zeros on the bus.
- R3: Request bit k (k = 0..6) stands for source code k+1. With exactly one request bit set, the select code equals that source code. The driver of the requests keeps at most one request bit set per cycle.
- R4: When the address register or program counter drives the bus, bus bits 15..12 read as zero.
- R5: Loading the address register or program counter captures bus bits 11..0 only.
- R6: Loading the output register captures bus bits 7..0 only.
- R7: Every strobe takes effect at the next rising clock edge. A register with no strobe active keeps its value.
- R8: For the address, program counter, data and temporary registers, clear has priority over load, and load has priority over increment.
- R9: The instruction register has only a load strobe and keeps its value while other registers are cleared or incremented.
- R10: Increment wraps modulo the register width (0xFFF+1 gives 0 for 12-bit registers, 0xFFFF+1 gives 0 for 16-bit ones).
- R11: The memory address output equals the address register, and the memory write data equals the bus.
- R12: A synchronous active-low reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 7 | One-hot bus source requests, bit k selects code k+1 |
| acc_in | input | 16 | Accumulator value offered as bus source 4 |
| mem_rdata | input | 16 | Memory read word offered as bus source 7 |
| ar_ld | input | 1 | Address register load |
| ar_inc | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load |
| pc_inc | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load |
| dr_inc | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| tr_ld | input | 1 | Temporary register load |
| tr_inc | input | 1 | Temporary register increment |
| tr_clr | input | 1 | Temporary register clear |
| ir_ld | input | 1 | Instruction register load |
| outr_ld | input | 1 | Output register load |
| bus_sel | output | 3 | Encoded bus select code |
| bus_out | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| tr_q | output | 16 | Temporary register |
| ir_q | output | 16 | Instruction register |
| outr_q | output | 8 | Output register |
| mem_addr | output | 12 | Memory address (from address register) |
| mem_wdata | output | 16 | Memory write word (the bus) |

## Verification
The bench builds the block with its default widths: a 16-bit bus, 12-bit address-side registers, an 8-bit output register and a 3-bit select code. At these sizes the 12-bit wrap point and the 16-bit wrap point can each be reached in two cycles, because a register can be loaded with all ones straight from the memory word. The upper-nibble zero-fill and the byte truncation are also visible with ordinary test words. Every strobe combination and all eight select codes come up within a few hundred random cycles against the behavioural model.

// File: rtl/busdp_pkg.sv
`timescale 1ns/1ps
// Package: widths and source codes shared by the bus datapath.
// Assumes a bus no narrower than the address registers or the output register.
package busdp_pkg;
    localparam int unsigned BUS_W   = 16;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned NUM_SRC = 1 << SEL_W;
    localparam int unsigned N_REQ   = NUM_SRC - 1;

    // Bus source codes; the order is fixed by the select encoding.
    localparam int unsigned SRC_NONE  = 0;
    localparam int unsigned SRC_ADDR  = 1;
    localparam int unsigned SRC_PROG  = 2;
    localparam int unsigned SRC_DATA  = 3;
    localparam int unsigned SRC_ACC   = 4;
    localparam int unsigned SRC_INSTR = 5;
    localparam int unsigned SRC_TEMP  = 6;
    localparam int unsigned SRC_MEM   = 7;
endpackage

// File: rtl/busdp_src_enc.sv
`timescale 1ns/1ps
// Module: busdp_src_enc
// Encodes one-hot source requests into a binary bus select code.
// Select bit b is the OR of every request whose source code has bit b set.
// Assumes at most one request is active per cycle.
module busdp_src_enc #(
    parameter int unsigned SEL_W = 3,
    localparam int unsigned N_REQ = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    output logic [SEL_W-1:0] sel
);
    // One OR tree per select bit, masked by the source codes carrying that bit.
    for (genvar b = 0; b < SEL_W; b++) begin : g_bit
        logic [N_REQ-1:0] code_mask;
        for (genvar k = 0; k < N_REQ; k++) begin : g_mask
            assign code_mask[k] = ((((k + 1) >> b) & 1) != 0);
        end
        assign sel[b] = |(req & code_mask);
    end

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    // R3
    req_nonzero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (sel != '0));
endmodule

// File: rtl/busdp_mux.sv
`timescale 1ns/1ps
// Module: busdp_mux
// Selects one of the source words onto the shared bus by select code.
// Assumes the caller has already width-adjusted every source to the bus.
module busdp_mux #(
    parameter int unsigned W     = 16,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned N    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     src [N],
    output logic [W-1:0]     bus
);
    // Plain indexed selection; code 0 is the caller's zero source.
    assign bus = src[sel];
endmodule

// File: rtl/busdp_reg.sv
`timescale 1ns/1ps
// Module: busdp_reg
// One bus destination register with synchronous clear, load and increment.
// Priority is clear, then load, then increment. HAS_INC / HAS_CLR remove
// strobes the register does not offer. Assumes d is already the bus slice.
module busdp_reg #(
    parameter int unsigned W       = 16,
    parameter bit          HAS_INC = 1'b1,
    parameter bit          HAS_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic inc_en;
    logic clr_en;

    // Strobes a variant does not have are forced inactive.
    assign inc_en = HAS_INC & inc;
    assign clr_en = HAS_CLR & clr;

    // Register update with fixed priority and synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (clr_en) q <= '0;
        else if (ld)     q <= d;
        else if (inc_en) q <= q + W'(1);
    end

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (q == '0));

    // R8
    ld_over_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr_en) |=> (q == $past(d)));

    // R10
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !ld && !clr_en) |=> (q == W'($past(q) + W'(1))));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !ld && !clr_en) |=> $stable(q));
endmodule

// File: rtl/busreg_datapath.sv
`timescale 1ns/1ps
// Module: busreg_datapath
// Shared 16-bit bus with seven sources and six destination registers.
// Narrow registers are zero-extended onto the bus and truncate on load.
// Assumes the external sequencer raises at most one source request a cycle.
module busreg_datapath
    import busdp_pkg::*;
#(
    parameter int unsigned P_BUS_W  = BUS_W,
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_CHAR_W = CHAR_W,
    parameter int unsigned P_SEL_W  = SEL_W,
    localparam int unsigned P_NREQ  = (1 << P_SEL_W) - 1,
    localparam int unsigned P_NSRC  = 1 << P_SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_NREQ-1:0]   src_req,
    input  logic [P_BUS_W-1:0]  acc_in,
    input  logic [P_BUS_W-1:0]  mem_rdata,
    input  logic                ar_ld,
    input  logic                ar_inc,
    input  logic                ar_clr,
    input  logic                pc_ld,
    input  logic                pc_inc,
    input  logic                pc_clr,
    input  logic                dr_ld,
    input  logic                dr_inc,
    input  logic                dr_clr,
    input  logic                tr_ld,
    input  logic                tr_inc,
    input  logic                tr_clr,
    input  logic                ir_ld,
    input  logic                outr_ld,
    output logic [P_SEL_W-1:0]  bus_sel,
    output logic [P_BUS_W-1:0]  bus_out,
    output logic [P_ADDR_W-1:0] ar_q,
    output logic [P_ADDR_W-1:0] pc_q,
    output logic [P_BUS_W-1:0]  dr_q,
    output logic [P_BUS_W-1:0]  tr_q,
    output logic [P_BUS_W-1:0]  ir_q,
    output logic [P_CHAR_W-1:0] outr_q,
    output logic [P_ADDR_W-1:0] mem_addr,
    output logic [P_BUS_W-1:0]  mem_wdata
);
    localparam int unsigned PAD_W = P_BUS_W - P_ADDR_W;

    logic [P_BUS_W-1:0] src_word [P_NSRC];

    // Request encoder producing the bus select code.
    busdp_src_enc #(.SEL_W(P_SEL_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (src_req),
        .sel   (bus_sel)
    );

    // Source table: fixed code order, narrow registers zero-extended.
    assign src_word[SRC_NONE]  = '0;
    assign src_word[SRC_ADDR]  = {{PAD_W{1'b0}}, ar_q};
    assign src_word[SRC_PROG]  = {{PAD_W{1'b0}}, pc_q};
    assign src_word[SRC_DATA]  = dr_q;
    assign src_word[SRC_ACC]   = acc_in;
    assign src_word[SRC_INSTR] = ir_q;
    assign src_word[SRC_TEMP]  = tr_q;
    assign src_word[SRC_MEM]   = mem_rdata;

    // Bus driver selection.
    busdp_mux #(.W(P_BUS_W), .SEL_W(P_SEL_W)) u_mux (
        .sel (bus_sel),
        .src (src_word),
        .bus (bus_out)
    );

    // Address register: low bus bits only, full strobe set.
    busdp_reg #(.W(P_ADDR_W)) u_ar (
        .clk(clk), .rst_n(rst_n), .ld(ar_ld), .inc(ar_inc), .clr(ar_clr),
        .d(bus_out[P_ADDR_W-1:0]), .q(ar_q)
    );

    // Program counter: low bus bits only, full strobe set.
    busdp_reg #(.W(P_ADDR_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .ld(pc_ld), .inc(pc_inc), .clr(pc_clr),
        .d(bus_out[P_ADDR_W-1:0]), .q(pc_q)
    );

    // Data register: full bus width, full strobe set.
    busdp_reg #(.W(P_BUS_W)) u_dr (
        .clk(clk), .rst_n(rst_n), .ld(dr_ld), .inc(dr_inc), .clr(dr_clr),
        .d(bus_out), .q(dr_q)
    );

    // Temporary register: full bus width, full strobe set.
    busdp_reg #(.W(P_BUS_W)) u_tr (
        .clk(clk), .rst_n(rst_n), .ld(tr_ld), .inc(tr_inc), .clr(tr_clr),
        .d(bus_out), .q(tr_q)
    );

    // Instruction register: load only.
    busdp_reg #(.W(P_BUS_W), .HAS_INC(1'b0), .HAS_CLR(1'b0)) u_ir (
        .clk(clk), .rst_n(rst_n), .ld(ir_ld), .inc(1'b0), .clr(1'b0),
        .d(bus_out), .q(ir_q)
    );

    // Output register: low byte of the bus, load only.
    busdp_reg #(.W(P_CHAR_W), .HAS_INC(1'b0), .HAS_CLR(1'b0)) u_outr (
        .clk(clk), .rst_n(rst_n), .ld(outr_ld), .inc(1'b0), .clr(1'b0),
        .d(bus_out[P_CHAR_W-1:0]), .q(outr_q)
    );

    // Memory side: address from the address register, write word from the bus.
    assign mem_addr  = ar_q;
    assign mem_wdata = bus_out;

    // R4
    narrow_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_sel == P_SEL_W'(SRC_ADDR)) || (bus_sel == P_SEL_W'(SRC_PROG)))
        |-> (bus_out[P_BUS_W-1:P_ADDR_W] == '0));

    // R9
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_ld |=> $stable(ir_q));
endmodule

// File: tb/busreg_datapath_bench.sv
`timescale 1ns/1ps
module busreg_datapath_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  src_req;
    logic [15:0] acc_in, mem_rdata;
    logic ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr;
    logic dr_ld, dr_inc, dr_clr, tr_ld, tr_inc, tr_clr, ir_ld, outr_ld;
    logic [2:0]  bus_sel;
    logic [15:0] bus_out, dr_q, tr_q, ir_q, mem_wdata;
    logic [11:0] ar_q, pc_q, mem_addr;
    logic [7:0]  outr_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_tag = "R7";

    // control word bit positions used by the stimulus
    localparam logic [13:0] AR_CLR = 14'd1 << 13, AR_LD = 14'd1 << 12, AR_INC = 14'd1 << 11;
    localparam logic [13:0] PC_CLR = 14'd1 << 10, PC_LD = 14'd1 << 9,  PC_INC = 14'd1 << 8;
    localparam logic [13:0] DR_CLR = 14'd1 << 7,  DR_LD = 14'd1 << 6,  DR_INC = 14'd1 << 5;
    localparam logic [13:0] TR_CLR = 14'd1 << 4,  TR_LD = 14'd1 << 3,  TR_INC = 14'd1 << 2;
    localparam logic [13:0] IR_LD  = 14'd1 << 1,  OUTR_LD = 14'd1;

    // reference model state
    int m_ar, m_pc, m_dr, m_tr, m_ir, m_outr;

    always #4 clk = ~clk;

    busreg_datapath u_busreg_datapath (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .acc_in(acc_in), .mem_rdata(mem_rdata),
        .ar_ld(ar_ld), .ar_inc(ar_inc), .ar_clr(ar_clr),
        .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr),
        .dr_ld(dr_ld), .dr_inc(dr_inc), .dr_clr(dr_clr),
        .tr_ld(tr_ld), .tr_inc(tr_inc), .tr_clr(tr_clr),
        .ir_ld(ir_ld), .outr_ld(outr_ld),
        .bus_sel(bus_sel), .bus_out(bus_out), .ar_q(ar_q), .pc_q(pc_q),
        .dr_q(dr_q), .tr_q(tr_q), .ir_q(ir_q), .outr_q(outr_q),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [6:0] X(input int k);
        return (k == 0) ? 7'd0 : 7'(1 << (k - 1));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int nxt(input bit c, input bit l, input bit i, input int cur,
                               input int d, input int mask);
        if (c) return 0;
        if (l) return d & mask;
        if (i) return (cur + 1) & mask;
        return cur;
    endfunction

    // one clock: drive at the falling edge, compare, advance the model
    task automatic step(input logic [6:0] r, input logic [15:0] a, input logic [15:0] m,
                        input logic [13:0] c, input bit rst);
        int e_sel, e_bus;
        @(negedge clk);
        src_req = r; acc_in = a; mem_rdata = m; rst_n = !rst;
        {ar_clr, ar_ld, ar_inc, pc_clr, pc_ld, pc_inc, dr_clr, dr_ld, dr_inc,
         tr_clr, tr_ld, tr_inc, ir_ld, outr_ld} = c;
        #1;
        chk("R3", "stimulus onehot", int'($countones(r) <= 1), 1);
        e_sel = 0;
        for (int k = 0; k < 7; k++) if (r[k]) e_sel = k + 1;
        case (e_sel)
            1: e_bus = m_ar;  2: e_bus = m_pc;  3: e_bus = m_dr;  4: e_bus = a;
            5: e_bus = m_ir;  6: e_bus = m_tr;  7: e_bus = m;     default: e_bus = 0;
        endcase
        chk("R3", "bus_sel", bus_sel, e_sel);
        chk(e_sel == 0 ? "R2" : "R1", "bus_out", bus_out, e_bus);
        chk(cur_tag, "ar_q", ar_q, m_ar);
        chk(cur_tag, "pc_q", pc_q, m_pc);
        chk(cur_tag, "dr_q", dr_q, m_dr);
        chk(cur_tag, "tr_q", tr_q, m_tr);
        chk(cur_tag, "ir_q", ir_q, m_ir);
        chk(cur_tag, "outr_q", outr_q, m_outr);
        chk("R11", "mem_addr", mem_addr, m_ar);
        chk("R11", "mem_wdata", mem_wdata, e_bus);
        @(posedge clk);
        if (rst) begin
            m_ar = 0; m_pc = 0; m_dr = 0; m_tr = 0; m_ir = 0; m_outr = 0;
        end else begin
            m_ar   = nxt(c[13], c[12], c[11], m_ar, e_bus, 'hFFF);
            m_pc   = nxt(c[10], c[9],  c[8],  m_pc, e_bus, 'hFFF);
            m_dr   = nxt(c[7],  c[6],  c[5],  m_dr, e_bus, 'hFFFF);
            m_tr   = nxt(c[4],  c[3],  c[2],  m_tr, e_bus, 'hFFFF);
            m_ir   = nxt(1'b0,  c[1],  1'b0,  m_ir, e_bus, 'hFFFF);
            m_outr = nxt(1'b0,  c[0],  1'b0,  m_outr, e_bus, 'hFF);
        end
        #1;
    endtask

    initial begin
        m_ar = 0; m_pc = 0; m_dr = 0; m_tr = 0; m_ir = 0; m_outr = 0;
        src_req = '0; acc_in = '0; mem_rdata = '0; rst_n = 1'b0;
        {ar_clr, ar_ld, ar_inc, pc_clr, pc_ld, pc_inc, dr_clr, dr_ld, dr_inc,
         tr_clr, tr_ld, tr_inc, ir_ld, outr_ld} = '0;
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);

        // R12: reset state
        cur_tag = "R12";
        step(0, 0, 0, 0, 0);
        chk("R12", "ar after reset", ar_q, 0);
        chk("R12", "ir after reset", ir_q, 0);

        // R2: no request gives zero bus
        chk("R2", "idle bus", bus_out, 0);

        // R5: 12-bit truncation on load
        cur_tag = "R5";
        step(X(7), 0, 16'hABCD, AR_LD | PC_LD, 0);
        chk("R5", "ar load", ar_q, 'hBCD);
        chk("R5", "pc load", pc_q, 'hBCD);

        // R4: zero-extension when narrow registers drive
        cur_tag = "R4";
        step(X(1), 0, 0, 0, 0);
        chk("R4", "ar on bus", bus_out, 'h0BCD);
        step(X(2), 0, 0, 0, 0);
        chk("R4", "pc on bus", bus_out, 'h0BCD);

        // R6: byte truncation on output register load
        cur_tag = "R6";
        step(X(4), 16'h1234, 0, OUTR_LD, 0);
        chk("R6", "outr load", outr_q, 'h34);

        // R8: priority clear > load > increment
        cur_tag = "R8";
        step(X(7), 0, 16'h0123, AR_LD | DR_LD, 0);
        step(X(7), 0, 16'h0456, AR_CLR | AR_LD | AR_INC | DR_CLR | DR_LD, 0);
        chk("R8", "ar clr over ld/inc", ar_q, 0);
        chk("R8", "dr clr over ld", dr_q, 0);
        step(X(7), 0, 16'h0456, AR_LD | AR_INC | TR_LD | TR_INC, 0);
        chk("R8", "ar ld over inc", ar_q, 'h456);
        chk("R8", "tr ld over inc", tr_q, 'h456);
        step(0, 0, 0, AR_CLR | AR_INC, 0);
        chk("R8", "ar clr over inc", ar_q, 0);

        // R10: wrap on increment
        cur_tag = "R10";
        step(X(7), 0, 16'hFFFF, AR_LD | DR_LD | PC_LD, 0);
        step(0, 0, 0, AR_INC | DR_INC | PC_INC, 0);
        chk("R10", "ar wrap", ar_q, 0);
        chk("R10", "pc wrap", pc_q, 0);
        chk("R10", "dr wrap", dr_q, 0);

        // R9: instruction register is load-only
        cur_tag = "R9";
        step(X(7), 0, 16'h5A5A, IR_LD, 0);
        for (int n = 0; n < 6; n++)
            step(X(6), 0, 16'h1111, AR_CLR | PC_INC | DR_CLR | TR_INC | TR_LD, 0);
        chk("R9", "ir held", ir_q, 'h5A5A);
        step(X(5), 0, 0, 0, 0);
        chk("R9", "ir on bus", bus_out, 'h5A5A);

        // R7 / R1 / R3: random strobes against the model
        cur_tag = "R7";
        for (int n = 0; n < 400; n++)
            step(X($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
                 14'($urandom), 0);

        // R12: reset in mid-run with strobes active
        cur_tag = "R12";
        step(X(7), 0, 16'hBEEF, 14'h3FFF, 1);
        step(0, 0, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule